// File: doc/BRIEF.md
# Synchronization Cell Window Decoder

This block owns the two map registers that place and size a memory window holding a bank of inter-thread synchronization cells, and it splits every offset inside that window into a cell select and an access view. Software reaches the map registers through a simple register port of 8-byte slots. Writes are masked per register, so only the configurable fields change.

The system address matcher uses three outputs to claim accesses: the window base, the window size and the window enable. The window size only moves to values that are a power of two; a request for any other size leaves the previous size in place. On the storage side, the cell stride is 128 bytes scaled up by a software grain field. Offsets past the last implemented cell select that last cell, so they never fault. The view code comes from four fixed offset bits. Codes with no defined view are flagged, and a read through such a view is marked for an all-ones return.

A one-cycle reconfigure pulse tells the fabric that the map contents changed. The cell counts are elaboration parameters; each count is limited to 16, and the sum must be at least 1.

Top module: `itc_window_decoder`

## Requirements
- R1: A write to slot 0 (byte address 0x00) updates only bits 31:10 (base) and bit 0 (enable) of map register 0. Every other bit keeps its previous value.
- R2: A write to slot 1 (byte address 0x08) updates only bits 16:10 (size mask) and bits 2:0 (grain) of map register 1. Every other bit keeps its previous value, including the cell count held at bits 25:20.
- R3: A write to any slot numbered 2 or higher changes no register and raises no reconfigure pulse. A read of any such slot returns zero.
- R4: After reset, register 0 reads 0, and register 1 reads 0xC00 OR (total cell count shifted left by 20). The window size is 4096, the base is 0, the window is disabled and the reconfigure pulse is low.
- R5: `win_base` equals register 0 bits 31:10 followed by ten zero bits, and `win_en` equals register 0 bit 0.
- R6: For a size mask m, the candidate size is 1024*(m+1) bytes. It is taken as the window size only when it is a power of two; otherwise the previous size is kept.
- R7: The cell select equals the window offset shifted right by 7 plus the grain field.
- R8: A shifted offset at or above the total cell count (FIFO cells plus semaphore cells) selects the last cell, index total-1.
- R9: `view_code` is offset bits 6:3. Codes 0 to 5 are valid views: raw data 0, tag/control 1, empty/full blocking 2, empty/full non-blocking 3, counting blocking 4, counting non-blocking 5. `view_err` is high for codes 6 to 15.
- R10: `rd_all_ones` is high exactly when `acc_rd` is high and the view code is invalid.
- R11: `cfg_reconf` is high for the one cycle after a register write that changes a map register value. It stays low after a write that changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | REG_AW (6) | Register byte address; bits 2:0 are ignored |
| reg_wdata | input | 64 | Register write data |
| reg_rdata | output | 64 | Register read data for `reg_addr` |
| win_base | output | 32 | Window base address |
| win_size | output | SIZE_W (18) | Window size in bytes |
| win_en | output | 1 | Window enable |
| cfg_reconf | output | 1 | One-cycle pulse after a map change |
| acc_ofs | input | OFS_W (17) | Byte offset of an access inside the window |
| acc_rd | input | 1 | Current access is a read |
| cell_sel | output | CELL_W (5) | Selected cell index |
| view_code | output | 4 | Access view code |
| view_err | output | 1 | View code is not a defined view |
| rd_all_ones | output | 1 | Read through an invalid view returns all ones |

## Verification
The bench builds the block with 3 FIFO cells and 2 semaphore cells. With only five cells, offsets beyond the last cell are reachable at every one of the eight grain settings, so the clamp is swept together with every view code at both the start and the end of each stride. Because the size mask field is 7 bits wide, the bench can step through all 128 mask values. This covers every legal size and every rejected size, with the expected size carried forward arithmetically.

// File: rtl/itcw_pkg.sv
`timescale 1ns/1ps
// Shared constants and view codes for the synchronization cell window decoder.
// Assumes 64-bit map registers on 8-byte slots.
package itcw_pkg;
    localparam int          MAP_W       = 64;
    localparam logic [63:0] MAP0_WMASK  = 64'h0000_0000_FFFF_FC01;
    localparam logic [63:0] MAP1_WMASK  = 64'h0000_0000_0001_FC07;
    localparam logic [63:0] MAP1_SZMASK = 64'h0000_0000_0001_FC00;
    localparam int          CNT_LSB     = 20;
    localparam int          RESET_SPAN  = 4096;
    localparam int          STRIDE_MIN  = 7;
    localparam int          SZM_LSB     = 10;
    localparam int          SZM_W       = 7;
    localparam int          GRAIN_W     = 3;
    localparam int          BASE_LSB    = 10;
    localparam int          BASE_W      = 22;
    localparam int          VIEW_LSB    = 3;
    localparam int          VIEW_W      = 4;
    localparam int          MAX_CELLS_PER_KIND = 16;

    typedef enum logic [VIEW_W-1:0] {
        VW_RAW    = 4'd0,
        VW_TAG    = 4'd1,
        VW_EF_BLK = 4'd2,
        VW_EF_TRY = 4'd3,
        VW_PV_BLK = 4'd4,
        VW_PV_TRY = 4'd5
    } view_e;
endpackage

// File: rtl/itcw_map_regs.sv
`timescale 1ns/1ps
// Map register storage with masked writes and a reconfigure pulse.
// Assumes the slot index is reg_addr >> 3; slots 0 and 1 exist, the rest read zero.
module itcw_map_regs
    import itcw_pkg::*;
#(
    parameter int TOTAL_CELLS = 32,
    parameter int REG_AW      = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_we,
    input  logic [REG_AW-1:0]   reg_addr,
    input  logic [MAP_W-1:0]    reg_wdata,
    output logic [MAP_W-1:0]    reg_rdata,
    output logic [BASE_W-1:0]   base_field,
    output logic                en_bit,
    output logic [GRAIN_W-1:0]  grain,
    output logic                upd,
    output logic [SZM_W-1:0]    szm_next,
    output logic                reconf
);
    localparam int          IDX_W    = REG_AW - 3;
    localparam logic [63:0] MAP1_RST = (64'(RESET_SPAN - 1) & MAP1_SZMASK)
                                     | (64'(TOTAL_CELLS) << CNT_LSB);

    logic [MAP_W-1:0] map0, map1, merged0, merged1;
    logic [IDX_W-1:0] idx;
    logic             chg0, chg1;
    logic             unused_lsb;

    assign idx        = reg_addr[REG_AW-1:3];
    assign unused_lsb = ^reg_addr[2:0];

    // Merge write data into the writable fields of each register.
    always_comb begin
        merged0 = (reg_wdata & MAP0_WMASK) | (map0 & ~MAP0_WMASK);
        merged1 = (reg_wdata & MAP1_WMASK) | (map1 & ~MAP1_WMASK);
        chg0    = reg_we && (idx == IDX_W'(0)) && (merged0 != map0);
        chg1    = reg_we && (idx == IDX_W'(1)) && (merged1 != map1);
    end

    // Register update and the pulse that follows a real change.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            map0   <= '0;
            map1   <= MAP1_RST;
            reconf <= 1'b0;
        end else begin
            if (chg0) map0 <= merged0;
            if (chg1) map1 <= merged1;
            reconf <= chg0 | chg1;
        end
    end

    // Read mux: unmapped slots return zero.
    always_comb begin
        if (idx == IDX_W'(0))      reg_rdata = map0;
        else if (idx == IDX_W'(1)) reg_rdata = map1;
        else                       reg_rdata = '0;
    end

    assign base_field = map0[BASE_LSB +: BASE_W];
    assign en_bit     = map0[0];
    assign grain      = map1[GRAIN_W-1:0];
    assign upd        = chg0 | chg1;
    assign szm_next   = chg1 ? merged1[SZM_LSB +: SZM_W] : map1[SZM_LSB +: SZM_W];

    // R11
    reconf_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reconf |-> ((map0 != $past(map0)) || (map1 != $past(map1))));
    // R11
    quiet_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !reconf |-> ($stable(map0) && $stable(map1)));
    // R1
    map0_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((map0 ^ $past(map0)) & ~MAP0_WMASK) == 64'd0);
    // R2
    map1_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((map1 ^ $past(map1)) & ~MAP1_WMASK) == 64'd0);
endmodule

// File: rtl/itcw_size_track.sv
`timescale 1ns/1ps
// Holds the window size; takes a new size only when it is a power of two.
// Assumes upd marks a cycle in which a map register changes.
module itcw_size_track
    import itcw_pkg::*;
#(
    parameter int SIZE_W = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              upd,
    input  logic [SZM_W-1:0]  szm_next,
    output logic [SIZE_W-1:0] win_size
);
    logic [SZM_W:0]    units;
    logic              legal;
    logic [SIZE_W-1:0] cand;

    // Candidate size in 1 KiB units and its power-of-two test.
    always_comb begin
        units = {1'b0, szm_next} + (SZM_W+1)'(1);
        legal = (units & (units - (SZM_W+1)'(1))) == '0;
        cand  = SIZE_W'(units) << SZM_LSB;
    end

    // Size register: load only legal sizes on a change.
    always_ff @(posedge clk) begin
        if (!rst_n)            win_size <= SIZE_W'(RESET_SPAN);
        else if (upd && legal) win_size <= cand;
    end

    // R6
    size_pow2_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(win_size) == 1);
endmodule

// File: rtl/itcw_cell_decode.sv
`timescale 1ns/1ps
// Combinational decode of a window offset into a cell select and a view code.
// Assumes TOTAL_CELLS >= 1; out-of-range indices clamp to the last cell.
module itcw_cell_decode
    import itcw_pkg::*;
#(
    parameter int TOTAL_CELLS = 32,
    parameter int OFS_W       = 17,
    parameter int CELL_W      = 5
) (
    input  logic [OFS_W-1:0]   acc_ofs,
    input  logic [GRAIN_W-1:0] grain,
    input  logic               acc_rd,
    output logic [CELL_W-1:0]  cell_sel,
    output logic [VIEW_W-1:0]  view_code,
    output logic               view_err,
    output logic               rd_all_ones
);
    logic [3:0]       shift;
    logic [OFS_W-1:0] raw;

    // Stride shift and clamped cell index.
    always_comb begin
        shift    = 4'(STRIDE_MIN) + 4'(grain);
        raw      = acc_ofs >> shift;
        cell_sel = (raw >= OFS_W'(TOTAL_CELLS)) ? CELL_W'(TOTAL_CELLS - 1)
                                                : raw[CELL_W-1:0];
    end

    // View field and its validity.
    always_comb begin
        view_code   = acc_ofs[VIEW_LSB +: VIEW_W];
        view_err    = view_code > VW_PV_TRY;
        rd_all_ones = acc_rd && view_err;
    end

    // Range guard on the select seen by the cell bank.
    always_comb begin
        if (!$isunknown(cell_sel)) begin
            // R8
            cell_bound_chk: assert (cell_sel <= CELL_W'(TOTAL_CELLS - 1));
        end
    end
endmodule

// File: rtl/itc_window_decoder.sv
`timescale 1ns/1ps
// Top: map registers, window size tracking and cell/view decode.
// Assumes each cell count is at most 16 and their sum is at least 1.
module itc_window_decoder
    import itcw_pkg::*;
#(
    parameter int FIFO_CELLS = 16,
    parameter int SEM_CELLS  = 16,
    parameter int REG_AW     = 6,
    parameter int OFS_W      = 17,
    parameter int SIZE_W     = 18,
    localparam int TOTAL_CELLS = FIFO_CELLS + SEM_CELLS,
    localparam int CELL_W      = (TOTAL_CELLS > 1) ? $clog2(TOTAL_CELLS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [63:0]       reg_wdata,
    output logic [63:0]       reg_rdata,
    output logic [31:0]       win_base,
    output logic [SIZE_W-1:0] win_size,
    output logic              win_en,
    output logic              cfg_reconf,
    input  logic [OFS_W-1:0]  acc_ofs,
    input  logic              acc_rd,
    output logic [CELL_W-1:0] cell_sel,
    output logic [3:0]        view_code,
    output logic              view_err,
    output logic              rd_all_ones
);
    if (FIFO_CELLS > MAX_CELLS_PER_KIND || SEM_CELLS > MAX_CELLS_PER_KIND
        || TOTAL_CELLS < 1) begin : g_cfg_bad
        $error("cell counts out of range");
    end

    logic [BASE_W-1:0]  base_field;
    logic [GRAIN_W-1:0] grain;
    logic               upd;
    logic [SZM_W-1:0]   szm_next;

    itcw_map_regs #(.TOTAL_CELLS(TOTAL_CELLS), .REG_AW(REG_AW)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .base_field(base_field),
        .en_bit(win_en), .grain(grain), .upd(upd), .szm_next(szm_next),
        .reconf(cfg_reconf)
    );

    itcw_size_track #(.SIZE_W(SIZE_W)) u_size (
        .clk(clk), .rst_n(rst_n), .upd(upd), .szm_next(szm_next),
        .win_size(win_size)
    );

    itcw_cell_decode #(.TOTAL_CELLS(TOTAL_CELLS), .OFS_W(OFS_W), .CELL_W(CELL_W)) u_dec (
        .acc_ofs(acc_ofs), .grain(grain), .acc_rd(acc_rd), .cell_sel(cell_sel),
        .view_code(view_code), .view_err(view_err), .rd_all_ones(rd_all_ones)
    );

    assign win_base = {base_field, 10'b0};

    // R6
    size_follows_reconf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (win_size != $past(win_size)) |-> cfg_reconf);
endmodule

// File: tb/test_itc_window_decoder.sv
`timescale 1ns/1ps
// Bench: sweeps of register writes, size masks, grains, cells and views.
module test_itc_window_decoder;
    localparam int FIFO_N = 3, SEM_N = 2, TOT = 5;
    localparam int REG_AW = 6, OFS_W = 17, SIZE_W = 18, CELL_W = 3;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic              rst_n, reg_we, acc_rd;
    logic [REG_AW-1:0] reg_addr;
    logic [63:0]       reg_wdata, reg_rdata;
    logic [31:0]       win_base;
    logic [SIZE_W-1:0] win_size;
    logic              win_en, cfg_reconf, view_err, rd_all_ones;
    logic [OFS_W-1:0]  acc_ofs;
    logic [CELL_W-1:0] cell_sel;
    logic [3:0]        view_code;

    itc_window_decoder #(.FIFO_CELLS(FIFO_N), .SEM_CELLS(SEM_N), .REG_AW(REG_AW),
                         .OFS_W(OFS_W), .SIZE_W(SIZE_W)) i_itc_window_decoder (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .win_base(win_base),
        .win_size(win_size), .win_en(win_en), .cfg_reconf(cfg_reconf),
        .acc_ofs(acc_ofs), .acc_rd(acc_rd), .cell_sel(cell_sel),
        .view_code(view_code), .view_err(view_err), .rd_all_ones(rd_all_ones)
    );

    int n_chk = 0, n_err = 0;
    bit done = 1'b0;
    logic [63:0] exp0, exp1, rv;
    longint exp_size;

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic reg_write(input int idx, input logic [63:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = REG_AW'(idx * 8); reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic reg_read(input int idx, output logic [63:0] v);
        reg_addr = REG_AW'(idx * 8);
        #1;
        v = reg_rdata;
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
        acc_ofs = '0; acc_rd = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R4 reset state
        exp0 = 64'd0;
        exp1 = 64'hC00 | (64'(TOT) << 20);
        reg_read(0, rv); check("R4", "reg0", rv, exp0);
        reg_read(1, rv); check("R4", "reg1", rv, exp1);
        check("R4", "size", 64'(win_size), 64'd4096);
        check("R4", "base", 64'(win_base), 64'd0);
        check("R4", "en", 64'(win_en), 64'd0);
        check("R4", "reconf", 64'(cfg_reconf), 64'd0);

        // R3 unmapped slots
        for (int i = 2; i < 8; i++) begin
            reg_write(i, '1);
            check("R3", "reconf after unmapped write", 64'(cfg_reconf), 64'd0);
            reg_read(i, rv); check("R3", "unmapped read", rv, 64'd0);
        end
        reg_read(0, rv); check("R3", "reg0 untouched", rv, exp0);
        reg_read(1, rv); check("R3", "reg1 untouched", rv, exp1);

        // R11 write of identical value
        reg_write(0, 64'd0);
        check("R11", "no pulse on equal write", 64'(cfg_reconf), 64'd0);

        // R1 / R5 / R11 masked writes to register 0
        reg_write(0, '1);
        check("R11", "pulse on change", 64'(cfg_reconf), 64'd1);
        exp0 = 64'hFFFF_FC01;
        reg_read(0, rv); check("R1", "reg0 all ones", rv, exp0);
        check("R5", "base", 64'(win_base), 64'hFFFF_FC00);
        check("R5", "en", 64'(win_en), 64'd1);
        @(negedge clk);
        check("R11", "pulse one cycle only", 64'(cfg_reconf), 64'd0);
        reg_write(0, 64'h1234_5678_9ABC_DEF0);
        exp0 = 64'h9ABC_DC00;
        reg_read(0, rv); check("R1", "reg0 pattern", rv, exp0);
        check("R5", "base pattern", 64'(win_base), 64'h9ABC_DC00);
        check("R5", "en cleared", 64'(win_en), 64'd0);

        // R2 masked writes to register 1
        reg_write(1, '1);
        exp1 = 64'h51_FC07;
        reg_read(1, rv); check("R2", "reg1 all ones", rv, exp1);
        exp_size = 131072;
        check("R6", "size max", 64'(win_size), 64'(exp_size));

        // R6 full sweep of the size mask
        for (int m = 0; m < 128; m++) begin
            reg_write(1, 64'(m) << 10);
            exp1 = ((64'(m) << 10) & 64'h1_FC07) | (exp1 & ~64'h1_FC07);
            if (((m + 1) & m) == 0) exp_size = longint'(m + 1) * 1024;
            reg_read(1, rv); check("R2", "reg1 mask sweep", rv, exp1);
            check("R6", $sformatf("size for mask %0d", m), 64'(win_size), 64'(exp_size));
        end

        // R7 / R8 / R9 decode sweep over grains, cells and views
        for (int g = 0; g < 8; g++) begin
            int sh;
            reg_write(1, 64'(g));
            sh = 7 + g;
            for (int k = 0; k < TOT + 2; k++) begin
                for (int v = 0; v < 16; v++) begin
                    for (int e = 0; e < 2; e++) begin
                        int o, ec;
                        o = (e == 0) ? ((k << sh) | (v << 3))
                                     : ((k << sh) + (1 << sh) - 1 - ((15 - v) << 3));
                        acc_ofs = OFS_W'(o);
                        #1;
                        ec = ((o >> sh) >= TOT) ? TOT - 1 : (o >> sh);
                        if ((o >> sh) >= TOT)
                            check("R8", $sformatf("clamp ofs %0h", o), 64'(cell_sel), 64'(ec));
                        else
                            check("R7", $sformatf("cell ofs %0h", o), 64'(cell_sel), 64'(ec));
                        check("R9", "view code", 64'(view_code), 64'(v));
                        check("R9", "view err", 64'(view_err), 64'(v > 5));
                    end
                end
            end
        end

        // R10 all-ones marking for reads through invalid views
        for (int v = 0; v < 16; v++) begin
            acc_ofs = OFS_W'(v << 3);
            acc_rd = 1'b1; #1;
            check("R10", "read marking", 64'(rd_all_ones), 64'(v > 5));
            acc_rd = 1'b0; #1;
            check("R10", "no read no marking", 64'(rd_all_ones), 64'd0);
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule